// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block holds the request levels that a slave controller raises toward a host over a mailbox link. The slave side has a small register bus. Through it the slave writes four outgoing data registers and three control registers that carry the enable bits for the host request lines. The host side has a read strobe and a register select. When the host reads a data register, the block sees it and uses the read to retire data-bound requests.

Channel 1 feeds the two keyboard-style lines, IRQ1 and IRQ12. Channels 2 and 3 each feed SMI, IRQ6, IRQ9, IRQ10 and IRQ11, and each of those channels has its own mode bit:

- **Mode 0 (data-bound):** a request can only be raised after the channel's data register has been written, and a host read of that register retires it.
- **Mode 1 (free-running):** a request is raised by the enable sequence alone and only the slave can drop it.

Channel 3 carries a second SMI source tied to an extra mailbox register. When channels 2 and 3 drive the same line, the host sees the OR of both. Bus framing and serial encoding of the request levels sit outside this block.

Top module: `host_irq_ctrl`

## Requirements
- R1: Synchronous active-low reset clears all enables, arm flags, pending flags, mode bits and data registers, so every request output and every readback is 0. Reset works from any state.
- R2: A write of 1 to an enable bit sets it only if a slave read of its control register found the bit at 0 and no write to that control register came between the read and this write.
- R3: In mode 0 the enable takes effect only after this order: slave writes the data register, then reads the control register, then writes 1 to the bit. The request output goes high in the cycle after that write. Data register addresses: 0 = channel 1, 1 = channel 2, 2 = channel 3, 3 = mailbox. Control register addresses: 4 = channel 1, 5 = channel 2, 6 = channel 3.
- R4: In mode 0, an enable write of 1 while the bound data register holds no unread data leaves the bit at 0 and the line low.
- R5: A slave write of 0 to an enable bit drops its request in the next cycle, in either mode.
- R6: In mode 0, a host read of a data register clears every enable bound to it and the pending flag. On channel 1 this clears both IRQ1 (control 4 bit 0) and IRQ12 (control 4 bit 1).
- R7: Bit 7 of control registers 5 and 6 is the channel mode and reads back as written. In mode 1 the enable sequence raises the request with no data write, and a host read leaves the request in place.
- R8: Channel 3 SMI has two independent sources. Source A is control 6 bit 0, bound to data register 2. Source B is control 6 bit 5, bound to the mailbox. A host read of one register retires only its own source, and the SMI output is the OR of channel 2 bit 0 and both channel 3 sources.
- R9: IRQ6, IRQ9, IRQ10 and IRQ11 use bits 1 to 4 of control 5 and 6 respectively. Each output is the OR of the channel 2 and channel 3 requests.
- R10: Any write to a control register consumes the arm flags of that register.
- R11: If a slave data write and a host read of the same data register fall in the same cycle, the data stays pending. If a host read retires an enable in the same cycle as a slave write of 1 to it, the host read wins.
- R12: The host read data output returns the data register picked by the host select. The slave readback of addresses 0 to 3 returns the same registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_addr | input | 3 | Slave register address |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe |
| s_wdata | input | 8 | Slave write data |
| s_rdata | output | 8 | Slave readback of the addressed register |
| h_rd | input | 1 | Host read strobe for a data register |
| h_sel | input | 2 | Host data register select |
| h_rdata | output | 8 | Host read data |
| irq1 | output | 1 | Channel 1 keyboard request |
| irq12 | output | 1 | Channel 1 auxiliary request |
| irq6 | output | 1 | IRQ6 request, channels 2 and 3 merged |
| irq9 | output | 1 | IRQ9 request, channels 2 and 3 merged |
| irq10 | output | 1 | IRQ10 request, channels 2 and 3 merged |
| irq11 | output | 1 | IRQ11 request, channels 2 and 3 merged |
| smi | output | 1 | SMI request, three sources merged |

## Verification
Two pairs of actions can land in the same cycle:

- A slave write to a data register and the host read of that register.
- A host read that retires an enable and a slave write of 1 to that enable.

The bench drives each pair in a single cycle. For the first pair, it judges the outcome by whether a later enable sequence still raises the line, which it can only do if the data stayed pending. For the second pair, it judges the outcome by the request output and the control readback right after the shared edge.

// File: rtl/host_irq_pkg.sv
// Shared constants of the host interrupt request controller: register
// addresses, bit positions and bank widths.
package host_irq_pkg;
    localparam int DW      = 8;
    localparam int AW      = 3;
    localparam int N_DREG  = 4;
    localparam int HSW     = $clog2(N_DREG);
    localparam int N_CH1   = 2;
    localparam int N_CH2   = 5;
    localparam int N_CH3   = 6;
    localparam int MODE_BIT = 7;

    localparam logic [AW-1:0] A_DAT1 = 3'd0;
    localparam logic [AW-1:0] A_DAT2 = 3'd1;
    localparam logic [AW-1:0] A_DAT3 = 3'd2;
    localparam logic [AW-1:0] A_MBOX = 3'd3;
    localparam logic [AW-1:0] A_CTL1 = 3'd4;
    localparam logic [AW-1:0] A_CTL2 = 3'd5;
    localparam logic [AW-1:0] A_CTL3 = 3'd6;
endpackage

// File: rtl/hirq_pend.sv
// Pending-data flags, one per data register.
// Assumes: set and clear are single-cycle strobes; set wins over clear.
module hirq_pend #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_q;

    // Flag follows slave writes (set) and host reads (clear).
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= set | (pend_q & ~clr);
    end

    assign pend = pend_q;
endmodule

// File: rtl/hirq_en_bank.sv
// Bank of enable bits guarded by a read-0 / write-1 arming rule.
// Assumes: wr_sel and rd_sel are never high together; gate says whether a
// new enable may take hold; hclr is a host-side retire that beats writes.
module hirq_en_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic         rd_sel,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] gate,
    input  logic [N-1:0] hclr,
    output logic [N-1:0] en
);
    logic [N-1:0] en_q;
    logic [N-1:0] arm_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Arm flag: set by reading the bit as 0, consumed by any write.
        always_ff @(posedge clk) begin
            if (!rst_n)                    arm_q[i] <= 1'b0;
            else if (wr_sel)               arm_q[i] <= 1'b0;
            else if (rd_sel && !en_q[i])   arm_q[i] <= 1'b1;
        end

        // Enable bit: host retire first, then slave write 0 / armed write 1.
        always_ff @(posedge clk) begin
            if (!rst_n)          en_q[i] <= 1'b0;
            else if (hclr[i])    en_q[i] <= 1'b0;
            else if (wr_sel) begin
                if (!wbits[i])                 en_q[i] <= 1'b0;
                else if (arm_q[i] && gate[i])  en_q[i] <= 1'b1;
            end
        end
    end

    assign en = en_q;
endmodule

// File: rtl/host_irq_ctrl.sv
// Host interrupt request controller: data registers, per-channel enable
// banks, pending tracking, mode bits and merging of the host lines.
// Assumes: single slave access per cycle; host strobe is one cycle wide.
module host_irq_ctrl
    import host_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  s_addr,
    input  logic           s_wr,
    input  logic           s_rd,
    input  logic [DW-1:0]  s_wdata,
    output logic [DW-1:0]  s_rdata,
    input  logic           h_rd,
    input  logic [HSW-1:0] h_sel,
    output logic [DW-1:0]  h_rdata,
    output logic           irq1,
    output logic           irq12,
    output logic           irq6,
    output logic           irq9,
    output logic           irq10,
    output logic           irq11,
    output logic           smi
);
    logic [DW-1:0]     dreg_q [N_DREG];
    logic [N_DREG-1:0] dwr;
    logic [N_DREG-1:0] hrd;
    logic [N_DREG-1:0] pend;
    logic              mode2_q, mode3_q;
    logic [N_CH1-1:0]  en1, g1, c1, r1;
    logic [N_CH2-1:0]  en2, g2, c2, r2;
    logic [N_CH3-1:0]  en3, g3, c3, r3;
    logic              wr_c1, wr_c2, wr_c3;
    logic              rd_c1, rd_c2, rd_c3;

    // Strobe decode for data registers on both sides.
    for (genvar j = 0; j < N_DREG; j++) begin : g_dreg
        assign dwr[j] = s_wr && (s_addr == AW'(j));
        assign hrd[j] = h_rd && (h_sel == HSW'(j));

        // Data register storage written by the slave.
        always_ff @(posedge clk) begin
            if (!rst_n)      dreg_q[j] <= '0;
            else if (dwr[j]) dreg_q[j] <= s_wdata;
        end
    end

    assign wr_c1 = s_wr && (s_addr == A_CTL1);
    assign wr_c2 = s_wr && (s_addr == A_CTL2);
    assign wr_c3 = s_wr && (s_addr == A_CTL3);
    assign rd_c1 = s_rd && !s_wr && (s_addr == A_CTL1);
    assign rd_c2 = s_rd && !s_wr && (s_addr == A_CTL2);
    assign rd_c3 = s_rd && !s_wr && (s_addr == A_CTL3);

    // Channel mode bits, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode2_q <= 1'b0;
            mode3_q <= 1'b0;
        end else begin
            if (wr_c2) mode2_q <= s_wdata[MODE_BIT];
            if (wr_c3) mode3_q <= s_wdata[MODE_BIT];
        end
    end

    hirq_pend #(.N(N_DREG)) u_pend (
        .clk(clk), .rst_n(rst_n), .set(dwr), .clr(hrd), .pend(pend)
    );

    // Gate: mode 1 needs nothing, mode 0 needs unread data.
    assign g1 = {N_CH1{pend[0]}};
    assign g2 = {N_CH2{mode2_q | pend[1]}};
    assign g3 = {mode3_q | pend[3], {(N_CH3-1){mode3_q | pend[2]}}};
    // Host retire only in mode 0.
    assign c1 = {N_CH1{hrd[0]}};
    assign c2 = {N_CH2{!mode2_q && hrd[1]}};
    assign c3 = {!mode3_q && hrd[3], {(N_CH3-1){!mode3_q && hrd[2]}}};

    hirq_en_bank #(.N(N_CH1)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_c1), .rd_sel(rd_c1),
        .wbits(s_wdata[N_CH1-1:0]), .gate(g1), .hclr(c1), .en(en1)
    );
    hirq_en_bank #(.N(N_CH2)) u_bank2 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_c2), .rd_sel(rd_c2),
        .wbits(s_wdata[N_CH2-1:0]), .gate(g2), .hclr(c2), .en(en2)
    );
    hirq_en_bank #(.N(N_CH3)) u_bank3 (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_c3), .rd_sel(rd_c3),
        .wbits(s_wdata[N_CH3-1:0]), .gate(g3), .hclr(c3), .en(en3)
    );

    assign r1 = en1 & g1;
    assign r2 = en2 & g2;
    assign r3 = en3 & g3;

    // Host line merge across channels.
    assign irq1  = r1[0];
    assign irq12 = r1[1];
    assign smi   = r2[0] | r3[0] | r3[N_CH3-1];
    assign irq6  = r2[1] | r3[1];
    assign irq9  = r2[2] | r3[2];
    assign irq10 = r2[3] | r3[3];
    assign irq11 = r2[4] | r3[4];

    // Slave readback mux.
    always_comb begin
        s_rdata = '0;
        case (s_addr)
            A_DAT1, A_DAT2, A_DAT3, A_MBOX: s_rdata = dreg_q[s_addr[HSW-1:0]];
            A_CTL1: s_rdata[N_CH1-1:0] = en1;
            A_CTL2: begin
                s_rdata[N_CH2-1:0]  = en2;
                s_rdata[MODE_BIT]   = mode2_q;
            end
            A_CTL3: begin
                s_rdata[N_CH3-1:0]  = en3;
                s_rdata[MODE_BIT]   = mode3_q;
            end
            default: s_rdata = '0;
        endcase
    end

    assign h_rdata = dreg_q[h_sel];
endmodule

// File: rtl/host_irq_ctrl_chk.sv
// Port-level checker for host_irq_ctrl, attached by bind.
// Assumes: observes only the top-level ports.
module host_irq_ctrl_chk
    import host_irq_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  s_addr,
    input logic           s_wr,
    input logic [DW-1:0]  s_wdata,
    input logic           h_rd,
    input logic [HSW-1:0] h_sel,
    input logic           irq1,
    input logic           irq12,
    input logic           irq6,
    input logic           irq9,
    input logic           irq10,
    input logic           irq11,
    input logic           smi
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(irq1 | irq12 | irq6 | irq9 | irq10 | irq11 | smi)); // R1
    AST_RISE_NEEDS_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq1) |-> $past(s_wr && s_addr == A_CTL1)); // R3
    AST_ZERO_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr && s_addr == A_CTL1 && !s_wdata[0]) |=> !irq1); // R5
    AST_HOST_READ_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_sel == 2'd0) |=> !(irq1 | irq12)); // R6
    AST_SMI_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi) |-> $past(s_wr || h_rd)); // R8
endmodule

bind host_irq_ctrl host_irq_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_wr(s_wr),
    .s_wdata(s_wdata), .h_rd(h_rd), .h_sel(h_sel), .irq1(irq1),
    .irq12(irq12), .irq6(irq6), .irq9(irq9), .irq10(irq10),
    .irq11(irq11), .smi(smi)
);

// File: tb/host_irq_ctrl_test.sv
module host_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    // Vector: {op[1:0], addr[2:0], data[7:0], exp[6:0]}
    // op 0 = slave write, 1 = slave read, 2 = host read (addr = select)
    // exp bits: 6 irq1, 5 irq12, 4 irq6, 3 irq9, 2 irq10, 1 irq11, 0 smi
    localparam int NV = 32;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 3'd4, 8'h03, 7'b0000000}, // R2 write 1 without read
        {2'd0, 3'd0, 8'h55, 7'b0000000},
        {2'd1, 3'd4, 8'h00, 7'b0000000},
        {2'd0, 3'd4, 8'h03, 7'b1100000}, // R3
        {2'd2, 3'd0, 8'h00, 7'b0000000}, // R6
        {2'd0, 3'd5, 8'h80, 7'b0000000},
        {2'd1, 3'd5, 8'h00, 7'b0000000},
        {2'd0, 3'd5, 8'h82, 7'b0010000}, // R7
        {2'd2, 3'd1, 8'h00, 7'b0010000}, // R7 host read no effect
        {2'd0, 3'd5, 8'h80, 7'b0000000}, // R5
        {2'd1, 3'd6, 8'h00, 7'b0000000},
        {2'd0, 3'd6, 8'h01, 7'b0000000}, // R4
        {2'd0, 3'd2, 8'hAA, 7'b0000000},
        {2'd0, 3'd3, 8'h11, 7'b0000000},
        {2'd1, 3'd6, 8'h00, 7'b0000000},
        {2'd0, 3'd6, 8'h21, 7'b0000001}, // R8
        {2'd2, 3'd3, 8'h00, 7'b0000001}, // R8 source A remains
        {2'd2, 3'd2, 8'h00, 7'b0000000}, // R8
        {2'd1, 3'd5, 8'h00, 7'b0000000},
        {2'd0, 3'd5, 8'h84, 7'b0001000}, // R9
        {2'd0, 3'd2, 8'h01, 7'b0001000},
        {2'd1, 3'd6, 8'h00, 7'b0001000},
        {2'd0, 3'd6, 8'h04, 7'b0001000}, // R9
        {2'd0, 3'd5, 8'h80, 7'b0001000}, // R9 channel 3 keeps line
        {2'd2, 3'd2, 8'h00, 7'b0000000},
        {2'd0, 3'd0, 8'h22, 7'b0000000},
        {2'd1, 3'd4, 8'h00, 7'b0000000},
        {2'd0, 3'd4, 8'h00, 7'b0000000},
        {2'd0, 3'd4, 8'h01, 7'b0000000}, // R10
        {2'd1, 3'd4, 8'h00, 7'b0000000},
        {2'd0, 3'd4, 8'h01, 7'b1000000},
        {2'd0, 3'd4, 8'h00, 7'b0000000}  // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] s_addr = '0;
    logic       s_wr = 1'b0, s_rd = 1'b0, h_rd = 1'b0;
    logic [7:0] s_wdata = '0;
    logic [1:0] h_sel = '0;
    logic [7:0] s_rdata, h_rdata;
    logic irq1, irq12, irq6, irq9, irq10, irq11, smi;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .h_rd(h_rd), .h_sel(h_sel),
        .h_rdata(h_rdata), .irq1(irq1), .irq12(irq12), .irq6(irq6),
        .irq9(irq9), .irq10(irq10), .irq11(irq11), .smi(smi)
    );

    function automatic logic [6:0] lines();
        return {irq1, irq12, irq6, irq9, irq10, irq11, smi};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, release at the next negedge.
    task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [7:0] d, input logic hr, input logic [1:0] hs);
        @(negedge clk);
        s_wr = wr; s_rd = rd; s_addr = a; s_wdata = d; h_rd = hr; h_sel = hs;
        @(negedge clk);
        s_wr = 1'b0; s_rd = 1'b0; h_rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 lines after reset", {1'b0, lines()}, 8'h00);
        s_addr = 3'd5; #1;
        check("R1 ctl2 readback", s_rdata, 8'h00);
        h_sel = 2'd2; #1;
        check("R1 host data", h_rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [2:0] a;
            op = VEC[i][19:18];
            a  = VEC[i][17:15];
            case (op)
                2'd0: cyc(1'b1, 1'b0, a, VEC[i][14:7], 1'b0, 2'd0);
                2'd1: cyc(1'b0, 1'b1, a, 8'h00, 1'b0, 2'd0);
                default: cyc(1'b0, 1'b0, 3'd7, 8'h00, 1'b1, a[1:0]);
            endcase
            check($sformatf("R2-table vec %0d lines", i), {1'b0, lines()},
                  {1'b0, VEC[i][6:0]});
        end

        s_addr = 3'd5; #1;
        check("R7 mode bit readback", s_rdata, 8'h80);

        // R11 (a): data write and host read in one cycle keep data pending.
        cyc(1'b0, 1'b0, 3'd7, 8'h00, 1'b1, 2'd0);
        cyc(1'b1, 1'b0, 3'd0, 8'h77, 1'b1, 2'd0);
        cyc(1'b0, 1'b1, 3'd4, 8'h00, 1'b0, 2'd0);
        cyc(1'b1, 1'b0, 3'd4, 8'h01, 1'b0, 2'd0);
        check("R11 pending survives", {7'b0, irq1}, 8'h01);
        cyc(1'b1, 1'b0, 3'd4, 8'h00, 1'b0, 2'd0);

        // R11 (b): host retire beats armed write of 1.
        cyc(1'b0, 1'b1, 3'd4, 8'h00, 1'b0, 2'd0);
        cyc(1'b1, 1'b0, 3'd4, 8'h01, 1'b1, 2'd0);
        check("R11 host wins line", {7'b0, irq1}, 8'h00);
        s_addr = 3'd4; #1;
        check("R11 host wins readback", s_rdata, 8'h00);

        // R12 data readback on both sides.
        cyc(1'b1, 1'b0, 3'd1, 8'h3C, 1'b0, 2'd0);
        h_sel = 2'd1; s_addr = 3'd1; #1;
        check("R12 host data", h_rdata, 8'h3C);
        check("R12 slave data", s_rdata, 8'h3C);

        // R1 reset from an active state.
        cyc(1'b1, 1'b0, 3'd0, 8'h5A, 1'b0, 2'd0);
        cyc(1'b0, 1'b1, 3'd4, 8'h00, 1'b0, 2'd0);
        cyc(1'b1, 1'b0, 3'd4, 8'h03, 1'b0, 2'd0);
        check("R3 both ch1 lines", {1'b0, lines()}, 8'h60);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 mid-run reset lines", {1'b0, lines()}, 8'h00);
        s_addr = 3'd4; #1;
        check("R1 mid-run reset ctl1", s_rdata, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule